// File: doc/BRIEF.md
# Serial Receiver with Standby Wake-up

This block is an asynchronous serial receiver. It oversamples a single RX line with a baud tick that runs at sixteen times the bit rate. It assembles each frame into a shift register and hands complete characters to a receive data register. A receive-full flag tells software that a character is waiting. An overrun flag records a character that arrived while the previous one was still unread.

Software can put the receiver into standby. In standby, arriving characters are thrown away until the hardware sees the chosen wake-up condition, and the hardware then clears the standby bit by itself. There are two wake-up conditions to choose from. The first is a quiet line lasting a full character time after a frame. The second is a character whose top data bit is 1; that character is kept and delivered.

Software uses a small register port with three addresses: status, data and control. The receive-full and overrun flags are cleared by a two-step handshake: a status read, then a data read.

Top module: `wake_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits least significant bit first, then one stop bit. Each bit lasts 16 baud ticks and is decided by a two-of-three vote over the samples at ticks 7, 8 and 9 of the bit. A start bit whose vote is high is rejected as a glitch and produces no character.
- R2: When a character moves into the receive data register, the receive-full flag (status bit 7, address 0) sets. A read of address 1 returns that character.
- R3: The receive-full and overrun flags clear only on a read of address 1 that follows a read of address 0 that saw either flag at 1. A read of address 1 without that earlier status read leaves both flags set.
- R4: If a character completes while receive-full is still set, the overrun flag (status bit 6) sets and the data register keeps its old value.
- R5: Writes to address 0 have no effect. The status flags and the control bits are unchanged afterwards.
- R6: A write to address 2 sets standby from bit 1 and the wake select from bit 0, and reading address 2 returns the same two bits. While standby is 1, a character that does not meet the wake-up condition sets neither flag and does not change the data register.
- R7: With the wake select at 0, 160 baud ticks of continuous high line in idle, counted from the end of a frame, clear standby. The next character is delivered.
- R8: With the wake select at 1, a character whose bit 7 is 1 clears standby and is delivered. A character with bit 7 at 0 is discarded and standby stays set.
- R9: After reset, status, control and data all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idles high |
| baudTick | input | 1 | One-cycle strobe at 16x the bit rate |
| regAddr | input | 2 | Register address: 0 status, 1 data, 2 control |
| regRd | input | 1 | Read strobe; its side effects take place at the clock edge |
| regWr | input | 1 | Write strobe |
| regWdata | input | 2 | Write data: bit 1 standby, bit 0 wake select |
| regRdata | output | 8 | Read data for the addressed register |
| rxFull | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| standby | output | 1 | Receiver is in standby |

## Verification
The hardest state to reach from the ports is a standby receiver with a character just discarded and the idle counter partly run. There the bench must see standby still set before the quiet time expires, and then see it clear. The bench first waits out any earlier quiet period, so a stale idle event cannot fire. It then enables standby, sends a character, and checks the flags and the control bits within a few bit times of the stop bit. After that it holds the line high past the idle length and checks that the next character is delivered. The address-mark case sends a character with bit 7 at 0 and then one with bit 7 at 1, back to back, so that only the top data bit decides the wake-up.

// File: rtl/wake_rx_pkg.sv
package wake_rx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  // events reported by the datapath
  typedef struct packed {
    logic frameDone;
    logic idleDet;
    logic msb;
  } rxEvent_t;

  // strobes issued by the control
  typedef struct packed {
    logic loadData;
  } ctlStrobe_t;
endpackage

// File: rtl/wake_rx_datapath.sv
module wake_rx_datapath
  import wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 baudTick,
  input  ctlStrobe_t           strb,
  output rxEvent_t             evt,
  output logic [DATA_BITS-1:0] dataReg
);
  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int IDLE_TICKS = OVERSAMPLE * (DATA_BITS + 2);
  localparam int IDLE_W     = $clog2(IDLE_TICKS);
  localparam int BIT_W      = $clog2(DATA_BITS);

  logic [SYNC_STAGES-1:0] rxSync;
  logic                   rxBit;
  rxState_e               state;
  logic [CNT_W-1:0]       tickCnt;
  logic [BIT_W-1:0]       bitIdx;
  logic [1:0]             votes;
  logic                   majority;
  logic                   voteNow;
  logic                   bitEnd;
  logic [DATA_BITS-1:0]   shiftReg;
  logic [IDLE_W-1:0]      idleCnt;
  logic                   idleArmed;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rxSync <= '1;
        else       rxSync <= {rxSync[SYNC_STAGES-2:0], rxIn};
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rxSync <= '1;
        else       rxSync <= rxIn;
    end
  endgenerate
  assign rxBit = rxSync[SYNC_STAGES-1];

  assign majority = (votes[0] & votes[1]) | (votes[0] & rxBit) | (votes[1] & rxBit);
  assign voteNow  = baudTick && (tickCnt == CNT_W'(MID + 1));
  assign bitEnd   = baudTick && (tickCnt == CNT_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= RX_IDLE;
      tickCnt       <= '0;
      bitIdx        <= '0;
      votes         <= '0;
      shiftReg      <= '0;
      evt.frameDone <= 1'b0;
    end else begin
      evt.frameDone <= 1'b0;
      if (baudTick) begin
        if (state == RX_IDLE) begin
          if (!rxBit) begin
            state   <= RX_START;
            tickCnt <= CNT_W'(1);
          end
        end else begin
          tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
          if (tickCnt == CNT_W'(MID - 1)) votes[0] <= rxBit;
          if (tickCnt == CNT_W'(MID))     votes[1] <= rxBit;
        end
      end
      if (voteNow) begin
        case (state)
          RX_START: if (majority) state <= RX_IDLE;
          RX_DATA:  shiftReg <= {majority, shiftReg[DATA_BITS-1:1]};
          RX_STOP: begin
            evt.frameDone <= 1'b1;
            state         <= RX_IDLE;
          end
          default: ;
        endcase
      end else if (bitEnd) begin
        case (state)
          RX_START: begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end
          RX_DATA:
            if (bitIdx == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // quiet-line detector, armed by each completed frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt     <= '0;
      idleArmed   <= 1'b0;
      evt.idleDet <= 1'b0;
    end else begin
      evt.idleDet <= 1'b0;
      if (evt.frameDone) begin
        idleArmed <= 1'b1;
        idleCnt   <= '0;
      end else if (state != RX_IDLE || !rxBit) begin
        idleCnt <= '0;
      end else if (baudTick && idleArmed) begin
        if (idleCnt == IDLE_W'(IDLE_TICKS - 1)) begin
          evt.idleDet <= 1'b1;
          idleArmed   <= 1'b0;
          idleCnt     <= '0;
        end else begin
          idleCnt <= idleCnt + 1'b1;
        end
      end
    end
  end

  assign evt.msb = shiftReg[DATA_BITS-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              dataReg <= '0;
    else if (strb.loadData) dataReg <= shiftReg;

  // R1
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.frameDone |=> !evt.frameDone);

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.idleDet |-> (rxBit && state == RX_IDLE));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadData |=> $stable(dataReg));
endmodule

// File: rtl/wake_rx_control.sv
module wake_rx_control
  import wake_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxEvent_t   evt,
  input  logic [1:0] regAddr,
  input  logic       regRd,
  input  logic       regWr,
  input  logic [1:0] regWdata,
  output ctlStrobe_t strb,
  output logic       rxFull,
  output logic       overrun,
  output logic       standby,
  output logic       wakeSel
);
  logic armed;
  logic deliver;
  logic wakeHit;
  logic clearNow;
  logic statusRd;
  logic ctrlWr;

  assign statusRd = regRd && (regAddr == ADDR_STATUS);
  assign ctrlWr   = regWr && (regAddr == ADDR_CTRL);
  assign clearNow = regRd && (regAddr == ADDR_DATA) && armed;
  assign deliver  = evt.frameDone && (!standby || (wakeSel && evt.msb));
  assign wakeHit  = standby && ((wakeSel && evt.frameDone && evt.msb) ||
                                (!wakeSel && evt.idleDet));
  assign strb.loadData = deliver && (!rxFull || clearNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      overrun <= 1'b0;
      armed   <= 1'b0;
      standby <= 1'b0;
      wakeSel <= 1'b0;
    end else begin
      if (strb.loadData)  rxFull <= 1'b1;
      else if (clearNow)  rxFull <= 1'b0;

      if (deliver && rxFull && !clearNow) overrun <= 1'b1;
      else if (clearNow)                  overrun <= 1'b0;

      if (clearNow)                                armed <= 1'b0;
      else if (statusRd && (rxFull || overrun))    armed <= 1'b1;

      if (ctrlWr) begin
        standby <= regWdata[1];
        wakeSel <= regWdata[0];
      end else if (wakeHit) begin
        standby <= 1'b0;
      end
    end
  end

  // R2
  rx_full_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(evt.frameDone));

  // R3
  rx_full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(regRd && regAddr == ADDR_DATA));

  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(evt.frameDone && rxFull));

  // R6
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (standby && evt.frameDone && !evt.msb && !ctrlWr) |=> !$rose(rxFull));

  // R8
  standby_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(standby) |-> $past(ctrlWr || evt.idleDet || evt.frameDone));
endmodule

// File: rtl/wake_rx.sv
module wake_rx
  import wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic [1:0] regAddr,
  input  logic       regRd,
  input  logic       regWr,
  input  logic [1:0] regWdata,
  output logic [7:0] regRdata,
  output logic       rxFull,
  output logic       overrun,
  output logic       standby
);
  rxEvent_t   evt;
  ctlStrobe_t strb;
  logic [7:0] dataReg;
  logic       wakeSel;

  wake_rx_datapath #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (8),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .rxIn    (rxIn),
    .baudTick(baudTick),
    .strb    (strb),
    .evt     (evt),
    .dataReg (dataReg)
  );

  wake_rx_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .regWdata(regWdata),
    .strb    (strb),
    .rxFull  (rxFull),
    .overrun (overrun),
    .standby (standby),
    .wakeSel (wakeSel)
  );

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdata = {rxFull, overrun, 6'b0};
      ADDR_DATA:   regRdata = dataReg;
      ADDR_CTRL:   regRdata = {6'b0, standby, wakeSel};
      default:     regRdata = 8'h00;
    endcase
  end

  // R5
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_STATUS) |=> $stable(standby));
endmodule

// File: tb/test_wake_rx.sv
module test_wake_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regWdata = 2'd0;
  logic [7:0] regRdata;
  logic       rxFull;
  logic       overrun;
  logic       standby;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam int BIT_CLKS = 32;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (!rstN) baudTick <= 1'b0;
    else       baudTick <= ~baudTick;

  wake_rx i_wake_rx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .rxFull(rxFull), .overrun(overrun), .standby(standby)
  );

  function automatic logic [7:0] expStatus(bit full, bit ovr);
    return {full, ovr, 6'b0};
  endfunction

  function automatic logic [7:0] expCtrl(bit sb, bit sel);
    return {6'b0, sb, sel};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regRead(logic [1:0] addr, output logic [7:0] val);
    @(negedge clk);
    regAddr = addr;
    regRd = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] addr, logic [1:0] val);
    @(negedge clk);
    regAddr = addr;
    regWdata = val;
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic sendBit(logic b);
    @(negedge clk);
    rxIn = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic sendChar(logic [7:0] c);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(c[i]);
    sendBit(1'b1);
  endtask

  task automatic quiet(int n);
    @(negedge clk);
    rxIn = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    regRead(2'd0, v); check("R9 status", v, expStatus(0, 0));
    regRead(2'd2, v); check("R9 control", v, expCtrl(0, 0));
    regRead(2'd1, v); check("R9 data", v, 8'h00);

    // R1 R2 basic reception with handshake
    sendChar(8'h5A);
    quiet(8);
    regRead(2'd0, v); check("R2 status after char", v, expStatus(1, 0));
    regRead(2'd1, v); check("R1 data 5A", v, 8'h5A);
    regRead(2'd0, v); check("R3 cleared", v, expStatus(0, 0));

    // R1 false start glitch
    @(negedge clk); rxIn = 1'b0;
    repeat (6) @(negedge clk);
    quiet(400);
    regRead(2'd0, v); check("R1 glitch rejected", v, expStatus(0, 0));

    // R4 overrun, R3 data read alone does not clear
    sendChar(8'h81);
    sendChar(8'h3C);
    quiet(8);
    regRead(2'd1, v); check("R4 data kept", v, 8'h81);
    regRead(2'd0, v); check("R4 overrun flag", v, expStatus(1, 1));
    regRead(2'd1, v); check("R3 data read", v, 8'h81);
    regRead(2'd0, v); check("R3 both cleared", v, expStatus(0, 0));

    // R5 status writes ignored
    regWrite(2'd0, 2'b11);
    regRead(2'd0, v); check("R5 status after write", v, expStatus(0, 0));
    regRead(2'd2, v); check("R5 control after write", v, expCtrl(0, 0));
    sendChar(8'hE7);
    quiet(8);
    regWrite(2'd0, 2'b00);
    regRead(2'd0, v); check("R5 full kept", v, expStatus(1, 0));
    regRead(2'd1, v); check("R5 data", v, 8'hE7);
    quiet(400);

    // R6 R7 idle-line wake-up
    regWrite(2'd2, 2'b10);
    regRead(2'd2, v); check("R6 control readback", v, expCtrl(1, 0));
    sendChar(8'hF0);
    quiet(4);
    regRead(2'd0, v); check("R6 suppressed status", v, expStatus(0, 0));
    regRead(2'd2, v); check("R7 still standby", v, expCtrl(1, 0));
    quiet(400);
    regRead(2'd2, v); check("R7 woke on idle", v, expCtrl(0, 0));
    sendChar(8'h42);
    quiet(8);
    regRead(2'd0, v); check("R7 next char full", v, expStatus(1, 0));
    regRead(2'd1, v); check("R7 next char data", v, 8'h42);
    quiet(400);

    // R8 address-mark wake-up
    regWrite(2'd2, 2'b11);
    sendChar(8'h35);
    quiet(4);
    regRead(2'd0, v); check("R8 msb0 discarded", v, expStatus(0, 0));
    regRead(2'd2, v); check("R8 still standby", v, expCtrl(1, 1));
    sendChar(8'hA7);
    quiet(8);
    regRead(2'd2, v); check("R8 woke", v, expCtrl(0, 1));
    regRead(2'd0, v); check("R8 status", v, expStatus(1, 0));
    regRead(2'd1, v); check("R8 data A7", v, 8'hA7);
    regRead(2'd0, v); check("R8 cleared", v, expStatus(0, 0));

    // R2 R3 random characters with random gaps
    regWrite(2'd2, 2'b00);
    for (int n = 0; n < 20; n++) begin
      logic [7:0] c;
      c = 8'($urandom);
      quiet($urandom_range(0, 60));
      sendChar(c);
      quiet(8);
      regRead(2'd0, v); check("R2 random status", v, expStatus(1, 0));
      regRead(2'd1, v); check("R1 random data", v, c);
      regRead(2'd0, v); check("R3 random clear", v, expStatus(0, 0));
    end

    finishRun();
  end
endmodule